// File: doc/BRIEF.md
# Open-Row Bank Access Controller

This block sits between a host request port and the command pins of a banked DRAM device. It remembers which row, if any, is open in each of 32 banks. It turns each read or write request into the shortest legal command sequence for that bank.

Every request is classified against the bank it targets:
- **Hit:** the requested row is already open, so only a column command is sent.
- **Miss:** a different row is open, so the controller closes it, opens the new row, then sends the column command.
- **Empty:** no row is open, so the controller opens the row, then sends the column command.

The 31-bit request address is split into bank-group, bank, row and column fields. It leaves the block in two phases over a 21-bit bus: the row phase travels with the open command and the column phase with the read or write.

Four cycle-counted gaps are enforced between commands. The block handles one request at a time. Its ready output stays low until the whole sequence has been issued and the column-to-data gap has run out.

Top module: `bank_row_ctrl`

## Requirements
- R1: A request address is split as bits [30:28] bank group, [27:26] bank, [25:10] row and [9:0] column; the 5-bit bank number is {group, bank}.
- R2: After reset every bank is empty, `req_ready` is 1, and `cmd_valid` and `stat_valid` are 0.
- R3: A request to an empty bank issues an open command (op 1) with bus = {bank, row} in the second cycle after acceptance, then the column command.
- R4: A request that hits the open row issues only the column command, in the second cycle after acceptance.
- R5: A request to a bank holding another row issues a close command (op 0, bus = {bank, 16'b0}), then an open command for the new row, then the column command.
- R6: Each bank keeps its own open row, so a row opened in one bank is unaffected by commands to other banks.
- R7: The column command comes exactly `T_RCD` cycles after the open command of the same sequence.
- R8: The open command comes exactly `T_RP` cycles after the close command of the same sequence.
- R9: A close command to a bank is issued no earlier than `T_RAS` cycles after that bank's last open command, and exactly then when that bound is the later constraint.
- R10: `req_ready` is 0 from acceptance until `T_CL` cycles after the column command, and returns to 1 in exactly that cycle.
- R11: In the cycle after acceptance, `stat_valid` pulses for one cycle with `stat_kind` 0 for hit, 1 for miss and 2 for empty.
- R12: The column command has op 3 for a write and op 2 for a read, with bus = {bank, 6'b0, column}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | 31 | Request address {group, bank, row, column} |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 0 close, 1 open, 2 read, 3 write |
| cmd_bus | output | 21 | Row-phase or column-phase address word |
| stat_valid | output | 1 | Classification pulse for the accepted request |
| stat_kind | output | 2 | 0 hit, 1 miss, 2 empty |

## Verification
Some properties are checked by assertions on every cycle:
- the command that follows each classification pulse (column for a hit, open for an empty bank, never a column for a miss);
- a quiet command bus whenever ready is high;
- no close command reaching a bank before its open-time counter has expired;
- an open command leaving its bank marked open.

Other behaviour can only be shown by the bench's sweep. This covers the exact cycle of every command against the four gaps, and the bus contents of both address phases. It also covers the independence of all 32 banks and ready returning in the right cycle. The sweep takes every bank through empty, miss and hit, then revisits all banks.

// File: rtl/brc_pkg.sv
// Shared encodings for the open-row bank access controller.
// Assumes: command and status codes are two bits wide.
package brc_pkg;
    typedef enum logic [1:0] {
        OP_PRE = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_WR  = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        K_HIT   = 2'd0,
        K_MISS  = 2'd1,
        K_EMPTY = 2'd2
    } acc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_PRE, S_ACT, S_COL, S_DRAIN
    } seq_state_e;
endpackage

// File: rtl/brc_addr_split.sv
// Splits a latched request address into bank number and the three bus words.
// Assumes: address layout {bank, row, col}, bus width = bank + row bits.
module brc_addr_split #(
    parameter int NB_W  = 5,
    parameter int ROW_W = 16,
    parameter int COL_W = 10,
    localparam int ADDR_W = NB_W + ROW_W + COL_W,
    localparam int BUS_W  = NB_W + ROW_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NB_W-1:0]   bank,
    output logic [BUS_W-1:0]  row_word,
    output logic [BUS_W-1:0]  col_word,
    output logic [BUS_W-1:0]  pre_word
);
    // Field extraction and phase word formation
    always_comb begin
        bank     = addr[ADDR_W-1 -: NB_W];
        row_word = addr[ADDR_W-1 -: BUS_W];
        col_word = {bank, {(ROW_W-COL_W){1'b0}}, addr[COL_W-1:0]};
        pre_word = {bank, {ROW_W{1'b0}}};
    end

    initial begin
        if (COL_W > ROW_W) $error("column field wider than row field");
    end
endmodule

// File: rtl/brc_gap_timer.sv
// Down-counter for the gap between successive commands of one sequence.
// Assumes: load has priority over clear; zero means the gap has elapsed.
module brc_gap_timer #(
    parameter int GW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] load_val,
    input  logic          clear,
    output logic          zero
);
    logic [GW-1:0] cnt;

    // Count down to zero after each load
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (clear)      cnt <= '0;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/brc_bank_table.sv
// Per-bank open-row record and open-to-close minimum counter.
// Assumes: at most one open and one close update per cycle.
module brc_bank_table #(
    parameter int NB_W  = 5,
    parameter int ROW_W = 16,
    parameter int T_RAS = 8,
    localparam int NB   = 1 << NB_W,
    localparam int RW   = $clog2(T_RAS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB_W-1:0]  lk_bank,
    output logic             lk_open,
    output logic [ROW_W-1:0] lk_row,
    output logic             lk_ras_ok,
    input  logic             act_we,
    input  logic [NB_W-1:0]  act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic             pre_we,
    input  logic [NB_W-1:0]  pre_bank
);
    logic [NB-1:0]    open_v;
    logic [ROW_W-1:0] open_r [NB];
    logic [NB-1:0]    ras_z;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [RW-1:0] ras_cnt;
        // Track the open row and the time since its opening for bank g
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_v[g] <= 1'b0;
                open_r[g] <= '0;
                ras_cnt   <= '0;
            end else if (act_we && act_bank == NB_W'(g)) begin
                open_v[g] <= 1'b1;
                open_r[g] <= act_row;
                ras_cnt   <= RW'(T_RAS - 1);
            end else begin
                if (pre_we && pre_bank == NB_W'(g)) open_v[g] <= 1'b0;
                if (ras_cnt != '0) ras_cnt <= ras_cnt - 1'b1;
            end
        end
        assign ras_z[g] = (ras_cnt == '0);
    end

    assign lk_open   = open_v[lk_bank];
    assign lk_row    = open_r[lk_bank];
    assign lk_ras_ok = ras_z[lk_bank];

    AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |-> ras_z[pre_bank]);  // R9
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_we |=> open_v[$past(act_bank)]);  // R6
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_we && !(act_we && act_bank == pre_bank)) |=> !open_v[$past(pre_bank)]);  // R5
endmodule

// File: rtl/bank_row_ctrl.sv
// Top: accepts one request at a time, classifies it against the bank table
// and issues close/open/column commands with cycle-counted gaps.
// Assumes: all timing gaps are at least 1 (T_CL at least 2), outputs registered.
module bank_row_ctrl
    import brc_pkg::*;
#(
    parameter int NB_W  = 5,
    parameter int ROW_W = 16,
    parameter int COL_W = 10,
    parameter int T_CL  = 4,
    parameter int T_RCD = 3,
    parameter int T_RP  = 2,
    parameter int T_RAS = 8,
    localparam int ADDR_W  = NB_W + ROW_W + COL_W,
    localparam int BUS_W   = NB_W + ROW_W,
    localparam int GAP_MAX = (T_CL > T_RCD) ? ((T_CL > T_RP) ? T_CL : T_RP)
                                            : ((T_RCD > T_RP) ? T_RCD : T_RP),
    localparam int GW      = $clog2(GAP_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BUS_W-1:0]  cmd_bus,
    output logic              stat_valid,
    output logic [1:0]        stat_kind
);
    seq_state_e        state;
    logic [ADDR_W-1:0] q_addr;
    logic              q_wr;
    cmd_op_e           op_q;
    acc_kind_e         kind_q;

    logic [NB_W-1:0]  in_bank, q_bank, lk_bank;
    logic [ROW_W-1:0] in_row, lk_row;
    logic [BUS_W-1:0] row_word, col_word, pre_word;
    logic             lk_open, lk_ras_ok, gap_zero;
    logic             accept, pre_go, act_go, col_go, gap_load;
    logic [GW-1:0]    gap_val;

    brc_addr_split #(.NB_W(NB_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_split (
        .addr(q_addr), .bank(q_bank), .row_word(row_word),
        .col_word(col_word), .pre_word(pre_word));

    // Incoming fields for classification and table lookup select
    always_comb begin
        in_bank = req_addr[ADDR_W-1 -: NB_W];
        in_row  = req_addr[COL_W +: ROW_W];
        lk_bank = (state == S_IDLE) ? in_bank : q_bank;
    end

    // Issue conditions for each command and gap reload
    always_comb begin
        req_ready = (state == S_IDLE);
        accept    = req_ready && req_valid;
        pre_go    = (state == S_PRE) && gap_zero && lk_ras_ok;
        act_go    = (state == S_ACT) && gap_zero;
        col_go    = (state == S_COL) && gap_zero;
        gap_load  = pre_go || act_go || col_go;
        gap_val   = pre_go ? GW'(T_RP - 1) : act_go ? GW'(T_RCD - 1) : GW'(T_CL - 1);
    end

    brc_bank_table #(.NB_W(NB_W), .ROW_W(ROW_W), .T_RAS(T_RAS)) u_table (
        .clk(clk), .rst_n(rst_n), .lk_bank(lk_bank), .lk_open(lk_open),
        .lk_row(lk_row), .lk_ras_ok(lk_ras_ok), .act_we(act_go),
        .act_bank(q_bank), .act_row(q_addr[COL_W +: ROW_W]),
        .pre_we(pre_go), .pre_bank(q_bank));

    brc_gap_timer #(.GW(GW)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val),
        .clear(accept), .zero(gap_zero));

    // Sequencer state, request latch and registered command/status outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            q_addr     <= '0;
            q_wr       <= 1'b0;
            cmd_valid  <= 1'b0;
            op_q       <= OP_PRE;
            cmd_bus    <= '0;
            stat_valid <= 1'b0;
            kind_q     <= K_HIT;
        end else begin
            cmd_valid  <= 1'b0;
            stat_valid <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    q_addr     <= req_addr;
                    q_wr       <= req_write;
                    stat_valid <= 1'b1;
                    if (lk_open && lk_row == in_row) begin
                        kind_q <= K_HIT;   state <= S_COL;
                    end else if (lk_open) begin
                        kind_q <= K_MISS;  state <= S_PRE;
                    end else begin
                        kind_q <= K_EMPTY; state <= S_ACT;
                    end
                end
                S_PRE: if (pre_go) begin
                    cmd_valid <= 1'b1; op_q <= OP_PRE; cmd_bus <= pre_word;
                    state     <= S_ACT;
                end
                S_ACT: if (act_go) begin
                    cmd_valid <= 1'b1; op_q <= OP_ACT; cmd_bus <= row_word;
                    state     <= S_COL;
                end
                S_COL: if (col_go) begin
                    cmd_valid <= 1'b1; op_q <= q_wr ? OP_WR : OP_RD;
                    cmd_bus   <= col_word;
                    state     <= S_DRAIN;
                end
                S_DRAIN: if (gap_zero) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign cmd_op    = op_q;
    assign stat_kind = kind_q;

    initial begin
        if (T_CL < 2 || T_RCD < 1 || T_RP < 1 || T_RAS < 1)
            $error("timing gaps out of range");
    end

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid);  // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> !req_ready);  // R10
    AST_STAT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> $past(req_valid && req_ready));  // R11
    AST_HIT_COL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_kind == 2'd0) |=> (cmd_valid && cmd_op[1]));  // R4
    AST_EMPTY_ACT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_kind == 2'd2) |=> (cmd_valid && cmd_op == 2'd1));  // R3
    AST_MISS_NO_COL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_kind == 2'd1) |=> !(cmd_valid && cmd_op[1]));  // R5
endmodule

// File: tb/tb_bank_row_ctrl.sv
module tb_bank_row_ctrl;
    localparam int CL = 4, RCD = 3, RP = 2, RAS = 12;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [30:0] req_addr = '0;
    logic        req_ready, cmd_valid, stat_valid;
    logic [1:0]  cmd_op, stat_kind;
    logic [20:0] cmd_bus;

    bank_row_ctrl #(.T_CL(CL), .T_RCD(RCD), .T_RP(RP), .T_RAS(RAS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bus(cmd_bus), .stat_valid(stat_valid),
        .stat_kind(stat_kind));

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_tests = 0, n_fail = 0;
    int nlog = 0;
    int log_op [512];
    int log_bus [512];
    int log_cyc [512];
    always @(negedge clk) if (cmd_valid && nlog < 512) begin
        log_op[nlog]  = int'(cmd_op);
        log_bus[nlog] = int'(cmd_bus);
        log_cyc[nlog] = cyc;
        nlog = nlog + 1;
    end

    bit m_open [32];
    int m_row [32];
    int m_act [32];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_req(input int b, input int row, input int col, input bit wr,
                          input string ctx);
        int e, kind, ncmd, n0, p, a, c, idx;
        while (!req_ready) @(negedge clk);
        req_addr  = {b[4:0], row[15:0], col[9:0]};
        req_write = wr;
        req_valid = 1'b1;
        @(posedge clk); #1;
        e = cyc;
        n0 = nlog;
        @(negedge clk);
        req_valid = 1'b0;
        // expected classification and command cycles from the model
        if (m_open[b] && m_row[b] == row) begin
            kind = 0; ncmd = 1; c = e + 1; a = -1; p = -1;
        end else if (m_open[b]) begin
            kind = 1; ncmd = 3;
            p = (e + 1 > m_act[b] + RAS) ? e + 1 : m_act[b] + RAS;
            a = p + RP; c = a + RCD;
        end else begin
            kind = 2; ncmd = 2; p = -1; a = e + 1; c = a + RCD;
        end
        chk(stat_valid == 1'b1, {"R11 stat_valid ", ctx}, int'(stat_valid), 1);
        chk(int'(stat_kind) == kind, {"R11 stat_kind ", ctx}, int'(stat_kind), kind);
        while (nlog < n0 + ncmd) @(negedge clk);
        #1;
        idx = n0;
        if (kind == 1) begin
            chk(log_op[idx] == 0, {"R5 close op ", ctx}, log_op[idx], 0);
            chk(log_bus[idx] == (b << 16), {"R5 close bus ", ctx}, log_bus[idx], b << 16);
            chk(log_cyc[idx] == p, {"R9 close cycle ", ctx}, log_cyc[idx], p);
            idx++;
        end
        if (kind != 0) begin
            chk(log_op[idx] == 1, {"R3 open op ", ctx}, log_op[idx], 1);
            chk(log_bus[idx] == ((b << 16) | row), {"R1 open bus ", ctx},
                log_bus[idx], (b << 16) | row);
            chk(log_cyc[idx] == a, {(kind == 1) ? "R8 open cycle " : "R3 open cycle ", ctx},
                log_cyc[idx], a);
            idx++;
        end
        chk(log_op[idx] == (wr ? 3 : 2), {"R12 column op ", ctx}, log_op[idx], wr ? 3 : 2);
        chk(log_bus[idx] == ((b << 16) | col), {"R12 column bus ", ctx},
            log_bus[idx], (b << 16) | col);
        chk(log_cyc[idx] == c, {(kind == 0) ? "R4 column cycle " : "R7 column cycle ", ctx},
            log_cyc[idx], c);
        // ready timing after the column command
        c = log_cyc[idx];
        while (cyc < c + CL - 1) @(negedge clk);
        chk(req_ready == 1'b0, {"R10 ready low ", ctx}, int'(req_ready), 0);
        @(negedge clk);
        chk(req_ready == 1'b1 && cyc == c + CL, {"R10 ready back ", ctx}, cyc, c + CL);
        chk(nlog == n0 + ncmd, {"R4 command count ", ctx}, nlog - n0, ncmd);
        if (kind != 0) begin
            m_open[b] = 1'b1; m_row[b] = row; m_act[b] = a;
        end
    endtask

    bit done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin
            m_open[i] = 1'b0; m_row[i] = 0; m_act[i] = -1000;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        chk(cmd_valid == 1'b0, "R2 no command after reset", int'(cmd_valid), 0);
        chk(stat_valid == 1'b0, "R2 no status after reset", int'(stat_valid), 0);
        // sweep every bank: empty, miss (open-time bound), hit
        for (int b = 0; b < 32; b++) begin
            do_req(b, b * 7 + 100, b * 3, 1'b0, $sformatf("bank %0d empty", b));
            do_req(b, b * 7 + 5000, b * 3 + 1, 1'b1, $sformatf("bank %0d miss", b));
            do_req(b, b * 7 + 5000, 1023 - b, b[0], $sformatf("bank %0d hit", b));
        end
        // revisit all banks: each still holds its own row
        for (int b = 31; b >= 0; b--)
            do_req(b, b * 7 + 5000, b + 7, ~b[0], $sformatf("R6 bank %0d revisit", b));
        // miss long after the open: the close gap alone binds
        repeat (30) @(negedge clk);
        do_req(9, 65535, 512, 1'b0, "late miss");
        do_req(9, 0, 0, 1'b1, "row zero miss");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule